// File: doc/BRIEF.md
# Edge-Latched Digital Input Interrupt Controller

This block watches eight asynchronous digital input lines and turns selected transitions on them into a single interrupt request for a CPU. Each line has two sticky event flags. One records a low-to-high transition and the other records a high-to-low transition. Each flag has its own enable bit. Any set flag drives one shared global interrupt flag, and that flag drives the interrupt output pin.

Software reaches the block over a byte-wide register bus with a 4-bit address. Through it, software:

- writes and reads the two enable masks,
- reads the rising flags, the falling flags, the global flag and the present input levels,
- clears one channel's two flags by reading that channel's clear address.

A write to the global-flag address pulls the interrupt output low for a short, fixed number of clocks and changes no flag. This gives a shared edge-triggered interrupt input at the CPU a fresh edge while flags are still pending.

Inputs pass through a two-stage synchronizer. An edge is the synchronized level differing from its value one clock earlier. Read data is combinational from the current address and state. A clear takes effect on the clock edge that samples the read strobe.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A rising flag for channel n sets one clock after the synchronized input n goes from 0 to 1, only when bit n of the rising enable mask (offset 0x8, bit n = channel n) is 1. It then stays set until cleared.
- R2: A falling flag for channel n sets one clock after the synchronized input n goes from 1 to 0, only when bit n of the falling enable mask (offset 0x9, bit n = channel n) is 1. It then stays set until cleared.
- R3: With both mask bits set, a channel flags both edges. With both masks zero, no input transition sets any flag and the interrupt output stays low.
- R4: A read of offset n (0 to 7) clears both flags of channel n, leaves other channels untouched, and returns 0x00. A write to offsets 0 to 7 changes nothing.
- R5: The interrupt output is high exactly when at least one flag is set and no low pulse is active. It stays high until the last flag is cleared.
- R6: Reads return the following:
  - 0x8: the rising mask.
  - 0x9: the falling mask.
  - 0xA: the global flag in bit 0 and zeros above.
  - 0xB: the rising flags, bit n = channel n.
  - 0xC: the falling flags, bit n = channel n.
  - 0xD: the synchronized input levels, bit n = channel n.
- R7: A write to offset 0xA forces the interrupt output low for PULSE_CLKS clocks, starting at the clock edge that samples the write, and changes no flag. A further write during the pulse restarts the count from that edge.
- R8: When an edge that would set a channel's flag and a clear read of that channel are sampled on the same clock edge, the flag is set afterwards.
- R9: While reset is low, all flags and both masks clear and the interrupt output is low.
- R10: Reads of offsets 0xE and 0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_async | input | NUM_CH | Asynchronous input levels, bit n = channel n |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
Two functions can meet on one clock edge: a new edge on a channel setting its flag, and a software clear read of that same channel. The bench counts synchronizer stages to place the clear read's strobe on the exact edge where the flag would set. It does this on a channel whose flag is already pending. It then judges the outcome by reading the rising status: the flag must still be set.

A clear read with no edge in flight is checked separately and must empty the flag, which shows that the surviving flag comes from the collision and not from a broken clear.

// File: rtl/eic_pkg.sv
// Package: register offsets shared by the register file, checker and bench.
// Assumes a 4-bit offset space and at most eight channels.
package eic_pkg;
    localparam int OFS_RISE_EN  = 8;
    localparam int OFS_FALL_EN  = 9;
    localparam int OFS_GLOBAL   = 10;
    localparam int OFS_RISE_ST  = 11;
    localparam int OFS_FALL_ST  = 12;
    localparam int OFS_LEVEL    = 13;
endpackage

// File: rtl/eic_input_sync.sv
// Module: two-flop synchronizer per input plus edge detection.
// Does: brings asynchronous levels into the clock domain and flags single-cycle
//       rise/fall pulses by comparing the synchronized level with its prior value.
// Assumes: inputs are stable for at least two clocks between transitions.
module eic_input_sync #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din_async,
    output logic [NUM_CH-1:0] level,
    output logic [NUM_CH-1:0] rise,
    output logic [NUM_CH-1:0] fall
);
    logic [NUM_CH-1:0] meta_q;
    logic [NUM_CH-1:0] sync_q;
    logic [NUM_CH-1:0] prev_q;

    // Purpose: two-stage capture and one-clock history of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: per-channel edge pulses from current and prior synchronized levels.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_edge
        assign rise[i] =  sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] &  prev_q[i];
    end

    assign level = sync_q;
endmodule

// File: rtl/eic_edge_latch.sv
// Module: the pair of sticky event flags for one channel.
// Does: sets the rising/falling flag on an enabled edge, clears both on request.
// Assumes: a set request on the same clock as a clear takes priority.
module eic_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic qr,
    output logic qf
);
    // Purpose: rising flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                qr <= 1'b0;
        else if (rise && rise_en)  qr <= 1'b1;
        else if (clr)              qr <= 1'b0;
    end

    // Purpose: falling flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                qf <= 1'b0;
        else if (fall && fall_en)  qf <= 1'b1;
        else if (clr)              qf <= 1'b0;
    end
endmodule

// File: rtl/eic_irq_pulse.sv
// Module: interrupt output stage with a restartable forced-low window.
// Does: passes the global flag to the pin except during PULSE_CLKS clocks after
//       each trigger; a trigger during the window reloads the counter.
// Assumes: PULSE_CLKS >= 1.
module eic_irq_pulse #(
    parameter int PULSE_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic gi,
    output logic irq_out
);
    localparam int CW = $clog2(PULSE_CLKS + 1);

    logic [CW-1:0] cnt_q;

    // Purpose: load on trigger, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (trigger)      cnt_q <= CW'(PULSE_CLKS);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: mask the global flag while the window is open.
    assign irq_out = gi & (cnt_q == '0);
endmodule

// File: rtl/eic_regs.sv
// Module: register file and address decode.
// Does: holds both enable masks, decodes per-channel clear reads and the pulse
//       trigger, and muxes read data combinationally.
// Assumes: one strobe per access; NUM_CH <= DATA_W.
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] qr,
    input  logic [NUM_CH-1:0] qf,
    input  logic [NUM_CH-1:0] level,
    input  logic              gi,
    output logic [NUM_CH-1:0] rise_mask,
    output logic [NUM_CH-1:0] fall_mask,
    output logic [NUM_CH-1:0] clr,
    output logic              pulse_trig,
    output logic [DATA_W-1:0] bus_rdata
);
    logic wr_rise;
    logic wr_fall;

    assign wr_rise    = bus_wr && (bus_addr == ADDR_W'(OFS_RISE_EN));
    assign wr_fall    = bus_wr && (bus_addr == ADDR_W'(OFS_FALL_EN));
    assign pulse_trig = bus_wr && (bus_addr == ADDR_W'(OFS_GLOBAL));

    // Purpose: rising enable mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        rise_mask <= '0;
        else if (wr_rise)  rise_mask <= bus_wdata[NUM_CH-1:0];
    end

    // Purpose: falling enable mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        fall_mask <= '0;
        else if (wr_fall)  fall_mask <= bus_wdata[NUM_CH-1:0];
    end

    // Purpose: one clear strobe per channel from a read of its own offset.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
        assign clr[i] = bus_rd && (bus_addr == ADDR_W'(i));
    end

    // Purpose: read data mux; clear offsets and unused offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_RISE_EN): bus_rdata = DATA_W'(rise_mask);
            ADDR_W'(OFS_FALL_EN): bus_rdata = DATA_W'(fall_mask);
            ADDR_W'(OFS_GLOBAL):  bus_rdata = DATA_W'(gi);
            ADDR_W'(OFS_RISE_ST): bus_rdata = DATA_W'(qr);
            ADDR_W'(OFS_FALL_ST): bus_rdata = DATA_W'(qf);
            ADDR_W'(OFS_LEVEL):   bus_rdata = DATA_W'(level);
            default:              bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
// Module: top of the edge-latched input interrupt controller.
// Does: synchronizes inputs, latches enabled edges per channel, ORs all flags
//       into the global flag and drives the interrupt pin through the pulse stage.
// Assumes: synchronous active-low reset; bus strobes are one clock wide.
module edge_irq_ctrl #(
    parameter int NUM_CH     = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int PULSE_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din_async,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic [NUM_CH-1:0] level;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] fall;
    logic [NUM_CH-1:0] qr_flags;
    logic [NUM_CH-1:0] qf_flags;
    logic [NUM_CH-1:0] rise_mask;
    logic [NUM_CH-1:0] fall_mask;
    logic [NUM_CH-1:0] clr;
    logic              pulse_trig;
    logic              global_flag;

    eic_input_sync #(.NUM_CH(NUM_CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din_async(din_async),
        .level(level), .rise(rise), .fall(fall)
    );

    // Purpose: one latch pair per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        eic_edge_latch u_latch (
            .clk(clk), .rst_n(rst_n),
            .rise(rise[i]), .fall(fall[i]),
            .rise_en(rise_mask[i]), .fall_en(fall_mask[i]),
            .clr(clr[i]), .qr(qr_flags[i]), .qf(qf_flags[i])
        );
    end

    // Purpose: global flag is high while any flag is pending.
    assign global_flag = (|qr_flags) | (|qf_flags);

    eic_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .qr(qr_flags), .qf(qf_flags), .level(level), .gi(global_flag),
        .rise_mask(rise_mask), .fall_mask(fall_mask), .clr(clr),
        .pulse_trig(pulse_trig), .bus_rdata(bus_rdata)
    );

    eic_irq_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trigger(pulse_trig),
        .gi(global_flag), .irq_out(irq_out)
    );
endmodule

// File: rtl/eic_checker.sv
// Module: assertion checker bound to edge_irq_ctrl.
// Does: relates flags, masks, bus strobes and the interrupt pin over time.
module eic_checker #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              irq_out,
    input logic [NUM_CH-1:0] qr,
    input logic [NUM_CH-1:0] qf,
    input logic [NUM_CH-1:0] rmask,
    input logic [NUM_CH-1:0] fmask
);
    // R5: the pin is never high without a pending flag.
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((qr != '0) || (qf != '0)));

    // R7: the clock after a pulse write the pin is low.
    a_r7_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(10)) |=> !irq_out);

    // R9: reset empties masks and flags and holds the pin low.
    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rmask == '0 && fmask == '0 && qr == '0 && qf == '0 && !irq_out));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R1: a rising flag only appears with its enable set.
        a_r1_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qr[i]) |-> $past(rmask[i]));
        // R2: a falling flag only appears with its enable set.
        a_r2_fall_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qf[i]) |-> $past(fmask[i]));
        // R4: a rising flag drops only after a clear read of its channel.
        a_r4_rise_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(qr[i]) |-> $past(bus_rd && bus_addr == ADDR_W'(i)));
        // R4: a falling flag drops only after a clear read of its channel.
        a_r4_fall_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(qf[i]) |-> $past(bus_rd && bus_addr == ADDR_W'(i)));
    end
endmodule

bind edge_irq_ctrl eic_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_eic_checker (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .irq_out(irq_out), .qr(qr_flags), .qf(qf_flags), .rmask(rise_mask), .fmask(fall_mask)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/100ps
module test_edge_irq_ctrl;
    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din_async = 8'h00;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_irq_ctrl #(.NUM_CH(8), .ADDR_W(4), .DATA_W(8), .PULSE_CLKS(P)) i_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .din_async(din_async), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic set_in(input logic [7:0] v);
        @(negedge clk);
        din_async = v;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic irq_now(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, {7'd0, irq_out}, {7'd0, exp});
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] rexp;
        logic [7:0] fexp;
        repeat (3) @(posedge clk);
        #1 chk("R9 irq in reset", {7'd0, irq_out}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R9: reset state visible on the bus
        bus_read(4'h8, d); chk("R9 rise mask", d, 8'h00);
        bus_read(4'h9, d); chk("R9 fall mask", d, 8'h00);
        bus_read(4'hB, d); chk("R9 rise flags", d, 8'h00);
        bus_read(4'hC, d); chk("R9 fall flags", d, 8'h00);

        // R3: masks zero, toggles raise nothing; R6 level readback
        set_in(8'hFF);
        bus_read(4'hD, d); chk("R6 level", d, 8'hFF);
        set_in(8'h00);
        bus_read(4'hB, d); chk("R3 no rise", d, 8'h00);
        bus_read(4'hC, d); chk("R3 no fall", d, 8'h00);
        irq_now("R3 irq low", 1'b0);

        // Sweep every channel and every mask combination
        for (int ch = 0; ch < 8; ch++) begin
            for (int m = 0; m < 4; m++) begin
                rexp = 8'((m & 1) << ch);
                fexp = 8'(((m >> 1) & 1) << ch);
                bus_write(4'h8, rexp);
                bus_write(4'h9, fexp);
                bus_read(4'h8, d); chk("R6 rise mask rb", d, rexp);
                bus_read(4'h9, d); chk("R6 fall mask rb", d, fexp);
                set_in(8'(1 << ch));
                bus_read(4'hD, d); chk("R6 level ch", d, 8'(1 << ch));
                bus_read(4'hB, d); chk("R1 rise flag", d, rexp);
                bus_read(4'hC, d); chk("R2 no fall yet", d, 8'h00);
                bus_read(4'hA, d); chk("R6 global", d, {7'd0, rexp != 0});
                irq_now("R5 irq", rexp != 0);
                set_in(8'h00);
                bus_read(4'hC, d); chk("R2 fall flag", d, fexp);
                bus_read(4'hB, d); chk("R3 rise kept", d, rexp);
                bus_write(4'(ch), 8'hFF);
                bus_read(4'hB, d); chk("R4 write no clear", d, rexp);
                bus_read(4'(ch), d); chk("R4 clear returns 0", d, 8'h00);
                bus_read(4'hB, d); chk("R4 rise cleared", d, 8'h00);
                bus_read(4'hC, d); chk("R4 fall cleared", d, 8'h00);
                irq_now("R5 irq cleared", 1'b0);
            end
        end

        // R5: global holds until the last flag is cleared; R4 other channel kept
        bus_write(4'h8, 8'hFF);
        bus_write(4'h9, 8'h00);
        set_in(8'h81);
        bus_read(4'h0, d);
        bus_read(4'hB, d); chk("R4 other channel kept", d, 8'h80);
        irq_now("R5 irq held", 1'b1);
        bus_read(4'hE, d); chk("R10 unused E", d, 8'h00);
        bus_read(4'hF, d); chk("R10 unused F", d, 8'h00);
        bus_read(4'h7, d);
        irq_now("R5 irq released", 1'b0);
        set_in(8'h00);

        // R7: forced low pulse with a pending flag
        set_in(8'h02);
        irq_now("R7 irq before pulse", 1'b1);
        bus_write(4'hA, 8'h00);
        chk("R7 low k0", {7'd0, irq_out}, 8'h00);
        for (int k = 1; k < P; k++) begin
            @(posedge clk); #1 chk("R7 low window", {7'd0, irq_out}, 8'h00);
        end
        @(posedge clk); #1 chk("R7 returns high", {7'd0, irq_out}, 8'h01);
        bus_read(4'hB, d); chk("R7 flags unchanged", d, 8'h02);
        // restart: write, wait, write again
        bus_write(4'hA, 8'h00);
        repeat (2) @(posedge clk);
        bus_write(4'hA, 8'h00);
        for (int k = 1; k < P; k++) begin
            @(posedge clk); #1 chk("R7 restarted window", {7'd0, irq_out}, 8'h00);
        end
        @(posedge clk); #1 chk("R7 restart end", {7'd0, irq_out}, 8'h01);
        bus_read(4'h1, d);
        set_in(8'h00);

        // R8: edge and clear of channel 0 on the same edge, flag already pending
        bus_write(4'h8, 8'h01);
        set_in(8'h01);
        set_in(8'h00);
        bus_read(4'hB, d); chk("R8 setup pending", d, 8'h01);
        @(negedge clk); din_async = 8'h01;
        @(posedge clk); @(posedge clk);
        #1 bus_addr = 4'h0; bus_rd = 1'b1;
        @(posedge clk);
        #1 bus_rd = 1'b0;
        bus_read(4'hB, d); chk("R8 edge wins", d, 8'h01);
        bus_read(4'h0, d);
        bus_read(4'hB, d); chk("R8 plain clear", d, 8'h00);

        // R9: reset again mid-run
        bus_write(4'h9, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 chk("R9 irq low in reset", {7'd0, irq_out}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        bus_read(4'h9, d); chk("R9 masks after reset", d, 8'h00);

        done = 1'b1;
        summary();
    end
endmodule